// File: doc/BRIEF.md
# Display Vertical Timing Generator with Programmable Line Interrupt

This block produces the vertical timing of a display controller. A frame opens at the first line of the vertical sync pulse; from there a line counter advances on every line-end pulse supplied by the horizontal timing logic and walks through four regions in fixed order: sync, back porch, active and front porch. The region boundaries come from four programmed line positions (sync end, active start, active end and frame total). The block drives a vertical sync output with selectable polarity and a vertical active flag.

Two interrupt sources are kept. A frame-sync event is recorded at every frame start. A line-flag event is recorded when the counter arrives at a programmed line number, independently of frame sync. Setting that number to the active-end line gives an event as soon as the visible data of a frame is complete. Both status bits are sticky, are cleared by per-bit strobes and are gated by per-bit enables onto a single request line. Status bit 0 is frame-sync and bit 1 is line-flag, and the enable and clear vectors use the same bit order.

The control flow is a five-state machine. `VT_IDLE` is held during reset. It moves to the region of line 0 on the first clock after reset. From then on, every counter step moves the machine among `VT_SYNC`, `VT_BACK`, `VT_ACTIVE` and `VT_FRONT`. The target is the region that holds the new line number: `VT_SYNC` while the line is below sync end, `VT_BACK` while it is below active start, `VT_ACTIVE` while it is below active end, and `VT_FRONT` for the rest. A frame wrap returns the machine to the region of line 0, which is normally `VT_SYNC`.

Top module: `disp_vtimer`

## Requirements
- R1: While reset is asserted, both status bits and the request are 0, the active flag is 0 and vsync sits at its inactive level.
- R2: The line counter is 0 at a frame start and increases by one per line-end pulse. The line-end pulse seen at line total-1 starts a new frame instead. A total of 0 or 1 makes every line-end pulse a frame start.
- R3: vsync is asserted on lines below sync end. It is active high when the polarity input is 1 and active low when it is 0. The polarity input takes effect immediately.
- R4: The active flag is high only on lines that are at or above sync end, at or above active start and below active end.
- R5: Status bit 0 (frame-sync) is set in the cycle after each frame start.
- R6: Status bit 1 (line-flag) is set in the cycle after the counter takes a value equal to the flag line, including the value 0 at a frame start. A flag line greater than the total never sets it.
- R7: Each status bit is sticky and is set whatever its enable. A 1 on its clear bit clears it. A set and a clear in the same cycle leave it set.
- R8: The request output is high exactly when some status bit and its enable bit are both 1. The enables act immediately.
- R9: Sync end, active start, active end, total and flag line are captured only at a frame start. Changes between frame starts affect nothing until the next frame.
- R10: The first frame starts on the first clock edge after reset is released, with no line-end pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_end_i | input | 1 | One-cycle pulse at the end of each line |
| vs_end_i | input | LINE_W | First line after the sync pulse |
| act_start_i | input | LINE_W | First active line |
| act_end_i | input | LINE_W | First line after the active region |
| total_i | input | LINE_W | Lines per frame |
| flag_line_i | input | LINE_W | Line number that raises the line-flag event |
| vsync_pol_i | input | 1 | 1: vsync active high, 0: active low |
| irq_en_i | input | 2 | Enables, bit 0 frame-sync, bit 1 line-flag |
| irq_clr_i | input | 2 | Clear strobes, same bit order |
| vsync_o | output | 1 | Vertical sync |
| vactive_o | output | 1 | Vertical active region flag |
| irq_status_o | output | 2 | Sticky status, bit 0 frame-sync, bit 1 line-flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Frame-sync and line-flag land on the same edge when the flag line is 0, because a frame start also loads the counter with 0. The bench runs a phase with that setting and expects both status bits to rise together on every frame. A second collision is a clear strobe that meets a new event on the same edge. Random clear strobes under a short frame make this happen many times, and the cycle model requires the bit to remain set in that case.

// File: rtl/disp_vt_pkg.sv
package disp_vt_pkg;
    localparam int NUM_IRQ = 2;
    localparam int IRQ_FS  = 0;
    localparam int IRQ_LF  = 1;

    typedef enum logic [2:0] {
        VT_IDLE,
        VT_SYNC,
        VT_BACK,
        VT_ACTIVE,
        VT_FRONT
    } vt_state_e;
endpackage

// File: rtl/vt_line_counter.sv
module vt_line_counter #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end_i,
    input  logic [LINE_W-1:0] vs_end_i,
    input  logic [LINE_W-1:0] act_start_i,
    input  logic [LINE_W-1:0] act_end_i,
    input  logic [LINE_W-1:0] total_i,
    input  logic [LINE_W-1:0] flag_line_i,
    output logic              frame_start_o,
    output logic              step_o,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic [LINE_W-1:0] sh_total_o,
    output logic [LINE_W-1:0] sh_flag_o,
    output logic [LINE_W-1:0] nxt_cnt_o,
    output logic [LINE_W-1:0] nxt_vs_end_o,
    output logic [LINE_W-1:0] nxt_act_start_o,
    output logic [LINE_W-1:0] nxt_act_end_o,
    output logic [LINE_W-1:0] nxt_total_o,
    output logic [LINE_W-1:0] nxt_flag_o
);
    localparam int CW = LINE_W + 1;

    logic              started_q;
    logic [LINE_W-1:0] cnt_q;
    logic [LINE_W-1:0] sh_vs_end_q, sh_act_start_q, sh_act_end_q, sh_total_q, sh_flag_q;
    logic [CW-1:0]     cnt_plus1;
    logic              wrap;

    assign cnt_plus1     = {1'b0, cnt_q} + CW'(1);
    assign wrap          = cnt_plus1 >= {1'b0, sh_total_q};
    assign frame_start_o = !started_q || (line_end_i && wrap);
    assign step_o        = frame_start_o || line_end_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q      <= 1'b0;
            cnt_q          <= '0;
            sh_vs_end_q    <= '0;
            sh_act_start_q <= '0;
            sh_act_end_q   <= '0;
            sh_total_q     <= '0;
            sh_flag_q      <= '0;
        end else begin
            started_q <= 1'b1;
            if (frame_start_o) begin
                cnt_q          <= '0;
                sh_vs_end_q    <= vs_end_i;
                sh_act_start_q <= act_start_i;
                sh_act_end_q   <= act_end_i;
                sh_total_q     <= total_i;
                sh_flag_q      <= flag_line_i;
            end else if (line_end_i) begin
                cnt_q <= cnt_plus1[LINE_W-1:0];
            end
        end
    end

    always_comb begin
        if (frame_start_o) begin
            nxt_cnt_o       = '0;
            nxt_vs_end_o    = vs_end_i;
            nxt_act_start_o = act_start_i;
            nxt_act_end_o   = act_end_i;
            nxt_total_o     = total_i;
            nxt_flag_o      = flag_line_i;
        end else begin
            nxt_cnt_o       = line_end_i ? cnt_plus1[LINE_W-1:0] : cnt_q;
            nxt_vs_end_o    = sh_vs_end_q;
            nxt_act_start_o = sh_act_start_q;
            nxt_act_end_o   = sh_act_end_q;
            nxt_total_o     = sh_total_q;
            nxt_flag_o      = sh_flag_q;
        end
    end

    assign line_cnt_o = cnt_q;
    assign sh_total_o = sh_total_q;
    assign sh_flag_o  = sh_flag_q;
endmodule

// File: rtl/vt_region_fsm.sv
module vt_region_fsm
    import disp_vt_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              step_i,
    input  logic [LINE_W-1:0] nxt_cnt_i,
    input  logic [LINE_W-1:0] nxt_vs_end_i,
    input  logic [LINE_W-1:0] nxt_act_start_i,
    input  logic [LINE_W-1:0] nxt_act_end_i,
    input  logic              vsync_pol_i,
    output vt_state_e         state_o,
    output logic              vsync_o,
    output logic              vactive_o
);
    vt_state_e state_q, state_d, region;

    always_comb begin
        if (nxt_cnt_i < nxt_vs_end_i)         region = VT_SYNC;
        else if (nxt_cnt_i < nxt_act_start_i) region = VT_BACK;
        else if (nxt_cnt_i < nxt_act_end_i)   region = VT_ACTIVE;
        else                                  region = VT_FRONT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VT_IDLE:   if (frame_start_i) state_d = region;
            VT_SYNC:   if (step_i)        state_d = region;
            VT_BACK:   if (step_i)        state_d = region;
            VT_ACTIVE: if (step_i)        state_d = region;
            VT_FRONT:  if (step_i)        state_d = region;
            default:                      state_d = VT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        vsync_o   = vsync_pol_i ? (state_q == VT_SYNC) : (state_q != VT_SYNC);
        vactive_o = (state_q == VT_ACTIVE);
    end

    assign state_o = state_q;
endmodule

// File: rtl/vt_irq_ctrl.sv
module vt_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stat_q[i] <= 1'b0;
            else if (set_i[i]) stat_q[i] <= 1'b1;
            else if (clr_i[i]) stat_q[i] <= 1'b0;
        end
    end

    assign status_o = stat_q;
    assign irq_o    = |(stat_q & en_i);
endmodule

// File: rtl/disp_vtimer.sv
module disp_vtimer
    import disp_vt_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end_i,
    input  logic [LINE_W-1:0] vs_end_i,
    input  logic [LINE_W-1:0] act_start_i,
    input  logic [LINE_W-1:0] act_end_i,
    input  logic [LINE_W-1:0] total_i,
    input  logic [LINE_W-1:0] flag_line_i,
    input  logic              vsync_pol_i,
    input  logic [1:0]        irq_en_i,
    input  logic [1:0]        irq_clr_i,
    output logic              vsync_o,
    output logic              vactive_o,
    output logic [1:0]        irq_status_o,
    output logic              irq_o
);
    logic              frame_start, step;
    logic [LINE_W-1:0] line_cnt, sh_total, sh_flag;
    logic [LINE_W-1:0] nxt_cnt, nxt_vs_end, nxt_act_start, nxt_act_end, nxt_total, nxt_flag;
    logic [NUM_IRQ-1:0] irq_set;
    vt_state_e         state;

    vt_line_counter #(.LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .line_end_i(line_end_i),
        .vs_end_i(vs_end_i), .act_start_i(act_start_i), .act_end_i(act_end_i),
        .total_i(total_i), .flag_line_i(flag_line_i),
        .frame_start_o(frame_start), .step_o(step), .line_cnt_o(line_cnt),
        .sh_total_o(sh_total), .sh_flag_o(sh_flag),
        .nxt_cnt_o(nxt_cnt), .nxt_vs_end_o(nxt_vs_end), .nxt_act_start_o(nxt_act_start),
        .nxt_act_end_o(nxt_act_end), .nxt_total_o(nxt_total), .nxt_flag_o(nxt_flag)
    );

    vt_region_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .step_i(step),
        .nxt_cnt_i(nxt_cnt), .nxt_vs_end_i(nxt_vs_end), .nxt_act_start_i(nxt_act_start),
        .nxt_act_end_i(nxt_act_end), .vsync_pol_i(vsync_pol_i),
        .state_o(state), .vsync_o(vsync_o), .vactive_o(vactive_o)
    );

    always_comb begin
        irq_set         = '0;
        irq_set[IRQ_FS] = frame_start;
        irq_set[IRQ_LF] = step && (nxt_cnt == nxt_flag) && (nxt_flag <= nxt_total);
    end

    vt_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(irq_set), .clr_i(irq_clr_i),
        .en_i(irq_en_i), .status_o(irq_status_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/vt_checks.sv
module vt_checks #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [LINE_W-1:0] line_cnt,
    input logic [LINE_W-1:0] sh_total,
    input logic [LINE_W-1:0] sh_flag,
    input logic [1:0]        irq_clr,
    input logic [1:0]        irq_en,
    input logic [1:0]        irq_status,
    input logic              irq_o,
    input logic              vsync,
    input logic              vactive,
    input logic              vs_high
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_total > 1) |-> (line_cnt < sh_total)); // R2
    AST_FS_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> irq_status[0]); // R5
    AST_LF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && (sh_flag > sh_total) && !irq_status[1]) |=> !irq_status[1]); // R6
    AST_FS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[0] && !irq_clr[0]) |=> irq_status[0]); // R7
    AST_LF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !irq_clr[1]) |=> irq_status[1]); // R7
    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq_o); // R8
    AST_ACTIVE_NOT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        vactive |-> (vsync != vs_high)); // R4
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(sh_total) && $stable(sh_flag))); // R9
endmodule

bind disp_vtimer vt_checks #(.LINE_W(LINE_W)) u_vt_checks (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_cnt(line_cnt),
    .sh_total(sh_total), .sh_flag(sh_flag), .irq_clr(irq_clr_i), .irq_en(irq_en_i),
    .irq_status(irq_status_o), .irq_o(irq_o), .vsync(vsync_o), .vactive(vactive_o),
    .vs_high(vsync_pol_i)
);

// File: tb/disp_vtimer_bench.sv
module disp_vtimer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_end = 1'b0;
    logic [LW-1:0] vs_end = '0, act_start = '0, act_end = '0, total = '0, flag_line = '0;
    logic          vpol = 1'b1;
    logic [1:0]    en = '0, clr = '0;
    logic          vsync, vactive, irq;
    logic [1:0]    status;

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_vtimer #(.LINE_W(LW)) u_disp_vtimer (
        .clk(clk), .rst_n(rst_n), .line_end_i(line_end),
        .vs_end_i(vs_end), .act_start_i(act_start), .act_end_i(act_end),
        .total_i(total), .flag_line_i(flag_line), .vsync_pol_i(vpol),
        .irq_en_i(en), .irq_clr_i(clr),
        .vsync_o(vsync), .vactive_o(vactive), .irq_status_o(status), .irq_o(irq)
    );

    // reference model: 0 idle, 1 sync, 2 back, 3 active, 4 front
    int m_started, m_line, m_reg;
    int s_vs, s_as, s_ae, s_tot, s_flag;
    int m_st0, m_st1;

    function automatic int region_of(int c);
        if (c < s_vs) return 1;
        if (c < s_as) return 2;
        if (c < s_ae) return 3;
        return 4;
    endfunction

    task automatic model_step();
        int fs, stp, lf;
        if (!rst_n) begin
            m_started = 0; m_line = 0; m_reg = 0;
            s_vs = 0; s_as = 0; s_ae = 0; s_tot = 0; s_flag = 0;
            m_st0 = 0; m_st1 = 0;
            return;
        end
        fs  = (m_started == 0 || (line_end && (m_line + 1 >= s_tot))) ? 1 : 0;
        stp = (fs != 0 || line_end) ? 1 : 0;
        if (fs != 0) begin
            m_line = 0;
            s_vs = int'(vs_end); s_as = int'(act_start); s_ae = int'(act_end);
            s_tot = int'(total); s_flag = int'(flag_line);
        end else if (line_end) begin
            m_line = m_line + 1;
        end
        m_started = 1;
        if (stp != 0) m_reg = region_of(m_line);
        lf = (stp != 0 && m_line == s_flag && s_flag <= s_tot) ? 1 : 0;
        m_st0 = (fs != 0) ? 1 : ((m_st0 != 0 && !clr[0]) ? 1 : 0);
        m_st1 = (lf != 0) ? 1 : ((m_st1 != 0 && !clr[1]) ? 1 : 0);
    endtask

    task automatic check1(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL phase %s %s %s actual=%0b expected=%0b at %0t",
                     tag, req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic e_vs, e_va, e_irq;
        e_vs  = (m_reg == 1) ? vpol : !vpol;
        e_va  = (m_reg == 3);
        e_irq = (m_st0 != 0 && en[0]) || (m_st1 != 0 && en[1]);
        check1("R3", "vsync", vsync, e_vs);
        check1("R4", "vactive", vactive, e_va);
        check1("R5", "status[0]", status[0], m_st0 != 0);
        check1("R6", "status[1]", status[1], m_st1 != 0);
        check1("R8", "irq", irq, e_irq);
    endtask

    always begin
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare();
    end

    task automatic run(int n, bit rand_le, bit rand_clr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_end = rand_le ? (($urandom % 3) == 0) : 1'b1;
            clr      = rand_clr ? 2'($urandom % 4) : 2'b00;
        end
        @(negedge clk);
        line_end = 1'b0;
        clr = 2'b00;
    endtask

    task automatic setcfg(int v, int s, int e, int t, int f);
        vs_end = LW'(v); act_start = LW'(s); act_end = LW'(e); total = LW'(t); flag_line = LW'(f);
    endtask

    initial begin
        // R1: reset state, checked by the per-clock compare
        tag = "R1";
        setcfg(2, 4, 10, 13, 10);
        repeat (4) @(negedge clk);
        checks++;
        if (status !== 2'b00 || irq !== 1'b0 || vactive !== 1'b0 || vsync !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000", status, irq, vactive, vsync);
        end
        // R10: first frame starts right after release, no line pulse
        tag = "R10";
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (status[0] !== 1'b1) begin
            errors++;
            $display("FAIL R10 first frame status[0] actual=%0b expected=1", status[0]);
        end
        // R2/R5/R6: nominal frames, flag at end of active
        tag = "R2";
        run(60, 1'b0, 1'b0);
        run(80, 1'b1, 1'b0);
        // R3: active-low vsync
        tag = "R3";
        vpol = 1'b0;
        run(40, 1'b0, 1'b0);
        vpol = 1'b1;
        // R7/R8: enables on, random clears colliding with sets
        tag = "R7";
        en = 2'b11;
        setcfg(1, 2, 4, 5, 3);
        run(150, 1'b1, 1'b1);
        en = 2'b10;
        run(60, 1'b0, 1'b1);
        en = 2'b01;
        run(60, 1'b1, 1'b1);
        // R9: change timing mid-frame
        tag = "R9";
        en = 2'b11;
        run(3, 1'b0, 1'b0);
        setcfg(3, 5, 7, 9, 6);
        run(2, 1'b0, 1'b0);
        setcfg(1, 1, 8, 11, 2);
        run(60, 1'b1, 1'b1);
        // R6: flag beyond total never matches; flag 0 coincides with frame sync
        tag = "R6";
        clr = 2'b11;
        setcfg(2, 3, 6, 8, 20);
        run(50, 1'b0, 1'b0);
        setcfg(2, 3, 6, 8, 0);
        run(60, 1'b0, 1'b1);
        // R4: misordered and degenerate regions
        tag = "R4";
        setcfg(3, 6, 4, 10, 9);
        run(40, 1'b0, 1'b0);
        setcfg(0, 0, 7, 7, 7);
        run(40, 1'b1, 1'b1);
        // R2: totals of one and zero
        tag = "R2";
        setcfg(1, 1, 1, 1, 0);
        run(20, 1'b1, 1'b1);
        setcfg(0, 0, 0, 0, 0);
        run(20, 1'b0, 1'b1);
        // R1 again: reset in mid-run
        tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        setcfg(2, 4, 10, 13, 10);
        run(40, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule